// File: doc/BRIEF.md
# Buddy Block Allocator

This block keeps track of a pool of 2^K equal minimum-size units and gives them out as aligned blocks whose size is a power of two. A client asks for a block of order k, which is 2^k units. The allocator returns the unit index where that block starts, or reports that no block of that size is available. A client gives a block back by passing its start index and order. The allocator then joins the returned block with its neighbour of the same size ("buddy") whenever that neighbour is also free, and keeps joining upward as far as it can.

The state is one free bitmap per order. Bit p of the order-j bitmap means that the block starting at unit p·2^j, of size 2^j, is free. An allocation climbs the orders from k until it finds a free block. It then halves that block step by step down to order k, returning the other half of each split to the free maps. A release climbs the orders, absorbing one buddy per cycle. Both walks are bounded by the number of orders, so no request is ever tied to the pool size. Requests use a ready/valid start and finish with a one-cycle done pulse that carries a success flag.

Top module: `buddy_alloc`

## Requirements
- R1: After reset, ready is 1 and done is 0. The whole pool is a single free block of order K at index 0. A request for order K succeeds at index 0, and a second request fails.
- R2: An allocate request (req_op = 0) for order k uses the lowest order j ≥ k that holds a free block. Within that order it takes the free block with the lowest index. On success the returned index is a multiple of 2^k and rsp_order equals k.
- R3: When the block taken has order j > k, it is halved j−k times. The upper half of each split, at index base + 2^m and order m, goes back to the free maps. The lower half is kept and is the one returned.
- R4: An allocate fails (rsp_ok = 0) when no free block of order k or higher exists, even if the free units of smaller orders add up to 2^k or more.
- R5: A free request (req_op = 1) for index i and order k succeeds. While the current order m is below K and the buddy, at index i XOR 2^m, is free at order m, the two are merged into one block at index i with bit m cleared, at order m+1. rsp_index and rsp_order report the block that finally lands in the free map.
- R6: Merging stops at the first order whose buddy is not free, or at order K.
- R7: A free request whose block overlaps any block that is already free, at the same order, a larger order or a smaller one, fails. It leaves every bitmap unchanged.
- R8: A request with order greater than K fails on the cycle after it is accepted. So does a free request whose index is not a multiple of 2^k. Neither changes any bitmap.
- R9: ready is 1 only while the block is idle. A request is taken only when req_valid and ready are both 1. req_valid while ready is 0 has no effect. done is a single-cycle pulse, one per accepted request.
- R10: done rises no more than 2K+1 clock edges after the edge that accepted the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, taken when ready is 1 |
| req_op | input | 1 | 0 = allocate, 1 = free |
| req_order | input | OW | Requested block order |
| req_index | input | K | Start unit of the block to free (ignored for allocate) |
| ready | output | 1 | Idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| rsp_ok | output | 1 | Result of the finished request: 1 = success |
| rsp_index | output | K | Index of the allocated block, or of the final merged block |
| rsp_order | output | OW | Order of the returned or merged block |

## Verification
The hardest situation to reach from the ports is a pool that is fragmented, where plenty of units are free but none at the size requested. The stimulus builds it by taking four quarter-size blocks and then returning two that are not buddies, so an allocation of half the pool has to fail. Cascading merges in the other direction are reached by taking one block of every order, which leaves a staircase of split halves. The blocks are then returned in an order that makes each release stop at a different height before the last one climbs to the full pool. Overlapping releases are tried against blocks that are free at a larger order and at the same order. A follow-up allocation then shows that the maps are still intact.

// File: rtl/buddy_pkg.sv
package buddy_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEARCH,
        ST_SPLIT,
        ST_MERGE,
        ST_DONE
    } buddy_state_e;

    typedef enum logic {
        OP_ALLOC = 1'b0,
        OP_FREE  = 1'b1
    } buddy_op_e;

    // Two unit ranges [a_base, a_base+a_len) and [b_base, b_base+b_len) intersect
    function automatic logic spans_meet(input int a_base, input int a_len,
                                        input int b_base, input int b_len);
        return (a_base < b_base + b_len) && (b_base < a_base + a_len);
    endfunction

endpackage

// File: rtl/buddy_pick.sv
// Lowest set bit of a vector
module buddy_pick #(
    parameter int N  = 64,
    parameter int PW = 6
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [PW-1:0] pos
);
    always_comb begin
        found = |vec;
        pos   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) pos = PW'(i);
        end
    end
endmodule

// File: rtl/buddy_overlap.sv
// Flags whether a candidate block intersects any block marked free at any order
module buddy_overlap #(
    parameter int K  = 6,
    parameter int OW = 3
) (
    input  logic [K:0][(1<<K)-1:0] fmap,
    input  logic [K-1:0]           idx,
    input  logic [OW-1:0]          ord,
    output logic                   hit
);
    import buddy_pkg::*;

    logic [K:0] hit_per_order;

    for (genvar j = 0; j <= K; j++) begin : g_ord
        localparam int SLOTS = 1 << (K - j);
        always_comb begin
            hit_per_order[j] = 1'b0;
            for (int p = 0; p < SLOTS; p++) begin
                if (fmap[j][p] &&
                    spans_meet(p << j, 1 << j, int'(idx), 1 << int'(ord)))
                    hit_per_order[j] = 1'b1;
            end
        end
    end

    assign hit = |hit_per_order;
endmodule

// File: rtl/buddy_alloc.sv
module buddy_alloc #(
    parameter int K  = 6,
    parameter int OW = $clog2(K + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_op,
    input  logic [OW-1:0] req_order,
    input  logic [K-1:0]  req_index,
    output logic          ready,
    output logic          done,
    output logic          rsp_ok,
    output logic [K-1:0]  rsp_index,
    output logic [OW-1:0] rsp_order
);
    import buddy_pkg::*;

    localparam int NUNITS = 1 << K;
    localparam logic [OW-1:0] TOP_ORD = OW'(K);

    buddy_state_e                state;
    logic [K:0][NUNITS-1:0]      fmap;
    logic [OW-1:0]               cur_ord;
    logic [OW-1:0]               tgt_ord;
    logic [K-1:0]                blk;

    // combinational views of the current step
    logic [NUNITS-1:0] cur_vec;
    logic              pick_found;
    logic [K-1:0]      pick_pos;
    logic [K-1:0]      blk_pos;
    logic [K-1:0]      buddy_pos;
    logic              buddy_free;
    logic [OW-1:0]     split_ord;
    logic [K-1:0]      split_pos;
    logic              req_ord_ok;
    logic [K-1:0]      align_mask;
    logic              req_aligned;
    logic              ovl_hit;

    always_comb begin
        cur_vec     = (cur_ord <= TOP_ORD) ? fmap[cur_ord] : '0;
        blk_pos     = blk >> cur_ord;
        buddy_pos   = blk_pos ^ K'(1);
        buddy_free  = (cur_ord < TOP_ORD) && cur_vec[buddy_pos];
        split_ord   = cur_ord - OW'(1);
        split_pos   = (blk >> split_ord) | K'(1);
        req_ord_ok  = req_order <= TOP_ORD;
        align_mask  = ~({K{1'b1}} << req_order);
        req_aligned = (req_index & align_mask) == '0;
    end

    buddy_pick #(.N(NUNITS), .PW(K)) u_pick (
        .vec   (cur_vec),
        .found (pick_found),
        .pos   (pick_pos)
    );

    buddy_overlap #(.K(K), .OW(OW)) u_ovl (
        .fmap (fmap),
        .idx  (req_index),
        .ord  (req_order),
        .hit  (ovl_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            fmap       <= '0;
            fmap[K][0] <= 1'b1;
            cur_ord    <= '0;
            tgt_ord    <= '0;
            blk        <= '0;
            rsp_ok     <= 1'b0;
            rsp_index  <= '0;
            rsp_order  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        tgt_ord <= req_order;
                        cur_ord <= req_order;
                        blk     <= req_index;
                        if (!req_ord_ok ||
                            (buddy_op_e'(req_op) == OP_FREE && (!req_aligned || ovl_hit))) begin
                            rsp_ok    <= 1'b0;
                            rsp_index <= req_index;
                            rsp_order <= req_order;
                            state     <= ST_DONE;
                        end else if (buddy_op_e'(req_op) == OP_ALLOC) begin
                            state <= ST_SEARCH;
                        end else begin
                            state <= ST_MERGE;
                        end
                    end
                end
                ST_SEARCH: begin
                    if (pick_found) begin
                        fmap[cur_ord][pick_pos] <= 1'b0;
                        blk <= pick_pos << cur_ord;
                        if (cur_ord == tgt_ord) begin
                            rsp_ok    <= 1'b1;
                            rsp_index <= pick_pos << cur_ord;
                            rsp_order <= cur_ord;
                            state     <= ST_DONE;
                        end else begin
                            state <= ST_SPLIT;
                        end
                    end else if (cur_ord == TOP_ORD) begin
                        rsp_ok    <= 1'b0;
                        rsp_index <= '0;
                        rsp_order <= tgt_ord;
                        state     <= ST_DONE;
                    end else begin
                        cur_ord <= cur_ord + OW'(1);
                    end
                end
                ST_SPLIT: begin
                    fmap[split_ord][split_pos] <= 1'b1;
                    cur_ord <= split_ord;
                    if (split_ord == tgt_ord) begin
                        rsp_ok    <= 1'b1;
                        rsp_index <= blk;
                        rsp_order <= split_ord;
                        state     <= ST_DONE;
                    end
                end
                ST_MERGE: begin
                    if (buddy_free) begin
                        fmap[cur_ord][buddy_pos] <= 1'b0;
                        blk     <= blk & ~(K'(1) << cur_ord);
                        cur_ord <= cur_ord + OW'(1);
                    end else begin
                        fmap[cur_ord][blk_pos] <= 1'b1;
                        rsp_ok    <= 1'b1;
                        rsp_index <= blk;
                        rsp_order <= cur_ord;
                        state     <= ST_DONE;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ready = (state == ST_IDLE);
    assign done  = (state == ST_DONE);

endmodule

// File: rtl/buddy_alloc_chk.sv
module buddy_alloc_chk #(
    parameter int K  = 6,
    parameter int OW = $clog2(K + 2)
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic [OW-1:0] req_order,
    input logic          ready,
    input logic          done,
    input logic          rsp_ok,
    input logic [K-1:0]  rsp_index,
    input logic [OW-1:0] rsp_order
);
    localparam int LAT_MAX = 2 * K + 1;

    logic [7:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst || ready) busy_cnt <= '0;
        else if (busy_cnt != 8'hFF) busy_cnt <= busy_cnt + 8'd1;
    end

    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: an accepted request drops ready on the next cycle
    a_r9_accept_busy: assert property (@(posedge clk) disable iff (rst)
        (ready && req_valid) |=> !ready);

    // R9: never idle and completing at once
    a_r9_ready_vs_done: assert property (@(posedge clk) disable iff (rst)
        !(ready && done));

    // R2: every successful response names a block aligned to its own size
    a_r2_aligned: assert property (@(posedge clk) disable iff (rst)
        (done && rsp_ok) |-> ((rsp_index & ~({K{1'b1}} << rsp_order)) == '0));

    // R8: an order above K is rejected right away
    a_r8_bad_order: assert property (@(posedge clk) disable iff (rst)
        (ready && req_valid && (int'(req_order) > K)) |=> (done && !rsp_ok));

    // R10: bounded walk length
    a_r10_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> (int'(busy_cnt) <= LAT_MAX));

endmodule

bind buddy_alloc buddy_alloc_chk #(.K(K), .OW(OW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_order (req_order),
    .ready     (ready),
    .done      (done),
    .rsp_ok    (rsp_ok),
    .rsp_index (rsp_index),
    .rsp_order (rsp_order)
);

// File: tb/buddy_alloc_test.sv
module buddy_alloc_test;
    localparam int K  = 6;
    localparam int OW = $clog2(K + 2);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_op = 1'b0;
    logic [OW-1:0] req_order = '0;
    logic [K-1:0]  req_index = '0;
    logic          ready, done, rsp_ok;
    logic [K-1:0]  rsp_index;
    logic [OW-1:0] rsp_order;

    int checks = 0;
    int errors = 0;

    buddy_alloc #(.K(K)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_order(req_order), .req_index(req_index), .ready(ready),
        .done(done), .rsp_ok(rsp_ok), .rsp_index(rsp_index), .rsp_order(rsp_order)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // issue one request, wait for done, return results and edges after acceptance
    task automatic do_req(input bit op, input int ord, input int idx,
                          output bit ok, output int ridx, output int rord, output int lat);
        @(negedge clk);
        while (!ready) @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_order = OW'(ord);
        req_index = K'(idx);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!done) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        ok   = rsp_ok;
        ridx = int'(rsp_index);
        rord = int'(rsp_order);
    endtask

    task automatic alloc_expect(input int ord, input bit exp_ok, input int exp_idx, input string req);
        bit ok; int ridx, rord, lat;
        do_req(1'b0, ord, 0, ok, ridx, rord, lat);
        chk(ok == exp_ok, req, ok, exp_ok);
        if (exp_ok) begin
            chk(ridx == exp_idx, req, ridx, exp_idx);
            chk(rord == ord, req, rord, ord);
        end
        chk(lat <= 2 * K + 1, "R10", lat, 2 * K + 1);
    endtask

    task automatic free_expect(input int idx, input int ord, input bit exp_ok,
                               input int exp_idx, input int exp_ord, input string req);
        bit ok; int ridx, rord, lat;
        do_req(1'b1, ord, idx, ok, ridx, rord, lat);
        chk(ok == exp_ok, req, ok, exp_ok);
        if (exp_ok) begin
            chk(ridx == exp_idx, req, ridx, exp_idx);
            chk(rord == exp_ord, req, rord, exp_ord);
        end
        chk(lat <= 2 * K + 1, "R10", lat, 2 * K + 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(ready == 1'b1, "R1 ready after reset", ready, 1);
        chk(done == 1'b0, "R1 done after reset", done, 0);
        alloc_expect(6, 1'b1, 0, "R1 whole pool");
        alloc_expect(0, 1'b0, 0, "R1 pool exhausted");
        free_expect(0, 6, 1'b1, 0, 6, "R6 free whole pool");
    endtask

    task automatic t_staircase();
        alloc_expect(0, 1'b1, 0,  "R3 split to order 0");
        alloc_expect(0, 1'b1, 1,  "R3 upper half order 0");
        alloc_expect(1, 1'b1, 2,  "R3 upper half order 1");
        alloc_expect(2, 1'b1, 4,  "R3 upper half order 2");
        alloc_expect(3, 1'b1, 8,  "R3 upper half order 3");
        alloc_expect(4, 1'b1, 16, "R3 upper half order 4");
        alloc_expect(5, 1'b1, 32, "R3 upper half order 5");
        alloc_expect(0, 1'b0, 0,  "R4 nothing left");
        free_expect(1, 0, 1'b1, 1, 0,   "R6 buddy busy no merge");
        free_expect(0, 0, 1'b1, 0, 1,   "R5 merge one step");
        free_expect(2, 1, 1'b1, 0, 2,   "R5 merge to order 2");
        free_expect(8, 3, 1'b1, 8, 3,   "R6 stop at busy buddy");
        free_expect(4, 2, 1'b1, 0, 4,   "R5 two-step cascade");
        free_expect(32, 5, 1'b1, 32, 5, "R6 buddy order 5 busy");
        free_expect(16, 4, 1'b1, 0, 6,  "R5 cascade to top");
    endtask

    task automatic t_fragment();
        alloc_expect(4, 1'b1, 0,  "R2 quarter 0");
        alloc_expect(4, 1'b1, 16, "R2 quarter 1");
        alloc_expect(4, 1'b1, 32, "R2 quarter 2");
        alloc_expect(4, 1'b1, 48, "R2 quarter 3");
        free_expect(0, 4, 1'b1, 0, 4,   "R6 non-buddy free 0");
        free_expect(32, 4, 1'b1, 32, 4, "R6 non-buddy free 32");
        alloc_expect(5, 1'b0, 0, "R4 fragmented pool");
        alloc_expect(4, 1'b1, 0, "R2 lowest index wins");
        free_expect(0, 4, 1'b1, 0, 4,   "R6 refree 0");
        free_expect(16, 4, 1'b1, 0, 5,  "R5 merge lower half");
        free_expect(48, 4, 1'b1, 0, 6,  "R5 merge to full pool");
    endtask

    task automatic t_smallest_order();
        alloc_expect(3, 1'b1, 0,  "R2 first order 3");
        alloc_expect(4, 1'b1, 16, "R2 exact order used");
        alloc_expect(3, 1'b1, 8,  "R2 order 3 preferred");
        alloc_expect(3, 1'b1, 32, "R2 climb to order 5");
        alloc_expect(3, 1'b1, 40, "R3 split leftover");
        free_expect(0, 3, 1'b1, 0, 3,   "R6 buddy 8 busy");
        free_expect(8, 3, 1'b1, 0, 4,   "R5 merge 0 and 8");
        free_expect(16, 4, 1'b1, 0, 5,  "R5 merge to order 5");
        free_expect(32, 3, 1'b1, 32, 3, "R6 buddy 40 busy");
        free_expect(40, 3, 1'b1, 0, 6,  "R5 three-step cascade");
    endtask

    task automatic t_bad_requests();
        free_expect(0, 0, 1'b0, 0, 0, "R7 inside free top block");
        free_expect(0, 6, 1'b0, 0, 0, "R7 top block already free");
        alloc_expect(7, 1'b0, 0, "R8 alloc order too big");
        free_expect(0, 7, 1'b0, 0, 0, "R8 free order too big");
        alloc_expect(2, 1'b1, 0, "R7 setup");
        free_expect(4, 2, 1'b0, 0, 0, "R7 same-order double free");
        free_expect(16, 3, 1'b0, 0, 0, "R7 free inside larger free block");
        free_expect(2, 2, 1'b0, 0, 0, "R8 misaligned free");
        alloc_expect(2, 1'b1, 4, "R7 maps intact after rejects");
        free_expect(0, 2, 1'b1, 0, 2, "R6 buddy 4 busy");
        free_expect(4, 2, 1'b1, 0, 6, "R5 rebuild pool");
        alloc_expect(6, 1'b1, 0, "R8 pool intact");
        free_expect(0, 6, 1'b1, 0, 6, "R8 release pool");
    endtask

    task automatic t_busy_ignore();
        int lat;
        int extra;
        @(negedge clk);
        while (!ready) @(negedge clk);
        req_valid = 1'b1; req_op = 1'b0; req_order = OW'(0); req_index = '0;
        @(posedge clk);
        @(negedge clk);
        chk(ready == 1'b0, "R9 ready low while busy", ready, 0);
        req_order = OW'(6);     // still valid, but not ready: must be ignored
        lat = 0;
        while (!done) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            req_valid = 1'b0;
        end
        chk(lat == 2 * K + 1, "R10 worst-case walk", lat, 2 * K + 1);
        chk(rsp_ok == 1'b1, "R9 first request ok", rsp_ok, 1);
        chk(int'(rsp_index) == 0, "R9 first request index", int'(rsp_index), 0);
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", done, 0);
        extra = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk(extra == 0, "R9 stray request ignored", extra, 0);
        free_expect(0, 0, 1'b1, 0, 6, "R5 full cascade from order 0");
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL R9 watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_staircase();
        t_fragment();
        t_smallest_order();
        t_bad_requests();
        t_busy_ignore();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule